// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a write-back, write-allocate data cache for 32-bit words. Its main storage is direct-mapped: sixteen lines of four words, with each address selecting exactly one line. A small fully associative side buffer of four lines sits beside the array. Every valid line pushed out of the array moves into that buffer instead of being dropped. When two blocks compete for the same set and are used in turn, they trade places between the array and the buffer, so neither is fetched again from the next level.

The processor issues one word read or write at a time through a valid/ready request port and receives a single-cycle response pulse. A lookup checks the array first. Only after an array miss is the side buffer searched. A buffer hit swaps the wanted line into the array and places the displaced line in the slot it came from. A true miss requests the whole line from the next level over a valid/ready channel. The new victim goes into the buffer slot named by a rotating pointer. If the line that currently holds that slot is dirty, it is written back first.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset, every line in the array and the buffer is invalid, `reqReady` is high, and `respValid` and `memReqValid` are low. The first access to any address is therefore a miss.
- R2: Address bits [3:2] select the word within a line, bits [7:4] select the set, and bits [31:8] form the tag. A read that hits the array returns the stored word and causes no next-level traffic.
- R3: A write that hits the array replaces only the addressed word and marks the line dirty. A later read of that word returns the written value, and neither access causes next-level traffic.
- R4: On a true miss, one line read is issued with `memReqWrite` low and `memReqAddr` equal to the request address with bits [3:0] cleared. Word w of `memRespLine` sits at bits [32w+31:32w]. The request is then completed from the filled line.
- R5: A valid line evicted from the array enters the buffer. A later access to it is served by a swap back into the array, with no next-level read.
- R6: Two blocks that share a set and are accessed alternately cause no next-level reads once both have been loaded.
- R7: A new victim from a refill goes into the slot at a rotating pointer that advances only on such an insertion. With four slots, the fifth line evicted since reset replaces the first.
- R8: A dirty line is written back before a refill reuses its buffer slot. The write uses `memReqWrite` high, the line's address with bits [3:0] cleared, and the line's current data. The dirty state travels with the line between the array and the buffer.
- R9: Clean lines that leave the buffer are dropped with no write to the next level.
- R10: `respValid` rises one cycle after the request is accepted for an array hit and three cycles after acceptance for a buffer hit. `reqReady` is high whenever `respValid` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request present |
| reqReady | output | 1 | Cache idle and able to accept a request |
| reqWrite | input | 1 | 1 = word write, 0 = word read |
| reqAddr | input | 32 | Byte address of the word |
| reqWdata | input | 32 | Write data |
| respValid | output | 1 | One-cycle completion pulse |
| respRdata | output | 32 | Read data, valid with respValid on reads |
| memReqValid | output | 1 | Next-level line request present |
| memReqReady | input | 1 | Next level accepts the request |
| memReqWrite | output | 1 | 1 = line write-back, 0 = line read |
| memReqAddr | output | 32 | Line-aligned byte address |
| memReqWline | output | 128 | Line data for a write-back |
| memRespValid | input | 1 | Read line returned |
| memRespLine | input | 128 | Returned line data |

## Verification
The bench targets a buffer hit whose swap loses the line's dirty state. Such a design would silently drop data, and that loss shows up later as a stale read after the line has gone through memory. It fills five conflicting lines into one set to confirm that the rotating pointer discards the oldest line. It also checks that the write-back of a dirty slot comes before the refill that reuses that slot. A design that wrote back the wrong slot, or skipped the write-back, would show the wrong write count, the wrong address, or stale memory contents. Ping-pong between two conflicting blocks is checked by counting next-level reads. A design that discards evicted lines would refill on every access. Random traffic with a stalling, delayed memory checks every read against a shadow image.

// File: rtl/vcache_pkg.sv
package vcache_pkg;

  typedef struct packed {
    logic latchReq;
    logic doAccess;
    logic doSwap;
    logic doFill;
    logic selWb;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_VSEARCH,
    S_WBREQ,
    S_FILLREQ,
    S_FILLWAIT
  } cacheState_t;

endpackage

// File: rtl/vcache_datapath.sv
module vcache_datapath
  import vcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 16,
  parameter int VB_DEPTH   = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrlStrobes_t                     strobes,
  input  logic                             reqWrite,
  input  logic [ADDR_W-1:0]                reqAddr,
  input  logic [WORD_W-1:0]                reqWdata,
  input  logic [WORD_W*LINE_WORDS-1:0]     memRespLine,
  output logic                             mainHit,
  output logic                             vbHit,
  output logic                             needWb,
  output logic                             respValid,
  output logic [WORD_W-1:0]                respRdata,
  output logic [ADDR_W-1:0]                memReqAddr,
  output logic [WORD_W*LINE_WORDS-1:0]     memReqWline
);

  localparam int LINE_W     = WORD_W * LINE_WORDS;
  localparam int LINE_BYTES = LINE_W / 8;
  localparam int BYTE_OFF   = $clog2(WORD_W / 8);
  localparam int WORD_OFF   = $clog2(LINE_WORDS);
  localparam int OFF_W      = BYTE_OFF + WORD_OFF;
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
  localparam int LADDR_W    = ADDR_W - OFF_W;
  localparam int PTR_W      = $clog2(VB_DEPTH);
  localparam int LSB_W      = $clog2(LINE_W);
  localparam int WBIT_W     = $clog2(WORD_W);

  // latched request
  logic [ADDR_W-1:0] curAddr;
  logic              curWrite;
  logic [WORD_W-1:0] curWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWrite <= 1'b0;
      curWdata <= '0;
    end else if (strobes.latchReq) begin
      curAddr  <= reqAddr;
      curWrite <= reqWrite;
      curWdata <= reqWdata;
    end
  end

  logic [IDX_W-1:0]    curIdx;
  logic [TAG_W-1:0]    curTag;
  logic [WORD_OFF-1:0] curWord;
  logic [LADDR_W-1:0]  curLine;
  logic [LSB_W-1:0]    wordLsb;

  assign curIdx  = curAddr[OFF_W +: IDX_W];
  assign curTag  = curAddr[ADDR_W-1 -: TAG_W];
  assign curWord = curAddr[BYTE_OFF +: WORD_OFF];
  assign curLine = curAddr[ADDR_W-1 -: LADDR_W];
  assign wordLsb = {curWord, {WBIT_W{1'b0}}};

  // main array
  logic [SETS-1:0]   lineValid;
  logic [SETS-1:0]   lineDirty;
  logic [TAG_W-1:0]  lineTag  [SETS];
  logic [LINE_W-1:0] lineData [SETS];

  // victim buffer
  logic [VB_DEPTH-1:0] vbValid;
  logic [VB_DEPTH-1:0] vbDirty;
  logic [LADDR_W-1:0]  vbLine [VB_DEPTH];
  logic [LINE_W-1:0]   vbData [VB_DEPTH];
  logic [PTR_W-1:0]    vbPtr;
  logic [PTR_W-1:0]    nextPtr;
  logic [VB_DEPTH-1:0] vbMatch;
  logic [PTR_W-1:0]    vbHitIdx;
  logic [LADDR_W-1:0]  evictLine;

  assign mainHit   = lineValid[curIdx] && (lineTag[curIdx] == curTag);
  assign evictLine = {lineTag[curIdx], curIdx};
  assign nextPtr   = (vbPtr == PTR_W'(VB_DEPTH - 1)) ? '0 : vbPtr + 1'b1;

  for (genvar g = 0; g < VB_DEPTH; g++) begin : g_vbCmp
    assign vbMatch[g] = vbValid[g] && (vbLine[g] == curLine);
  end

  always_comb begin
    vbHitIdx = '0;
    for (int i = 0; i < VB_DEPTH; i++) begin
      if (vbMatch[i]) vbHitIdx = PTR_W'(i);
    end
  end

  assign vbHit  = |vbMatch;
  assign needWb = lineValid[curIdx] && vbValid[vbPtr] && vbDirty[vbPtr];

  // valid / dirty / pointer state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineValid <= '0;
      lineDirty <= '0;
      vbValid   <= '0;
      vbDirty   <= '0;
      vbPtr     <= '0;
    end else begin
      if (strobes.doAccess && curWrite) lineDirty[curIdx] <= 1'b1;
      if (strobes.doSwap) begin
        lineValid[curIdx]  <= 1'b1;
        lineDirty[curIdx]  <= vbDirty[vbHitIdx];
        vbValid[vbHitIdx]  <= lineValid[curIdx];
        vbDirty[vbHitIdx]  <= lineDirty[curIdx];
      end
      if (strobes.doFill) begin
        lineValid[curIdx] <= 1'b1;
        lineDirty[curIdx] <= 1'b0;
        if (lineValid[curIdx]) begin
          vbValid[vbPtr] <= 1'b1;
          vbDirty[vbPtr] <= lineDirty[curIdx];
          vbPtr          <= nextPtr;
        end
      end
    end
  end

  // tag and data storage
  always_ff @(posedge clk) begin
    if (strobes.doAccess && curWrite) begin
      lineData[curIdx][wordLsb +: WORD_W] <= curWdata;
    end
    if (strobes.doSwap) begin
      lineTag[curIdx]  <= vbLine[vbHitIdx][LADDR_W-1 -: TAG_W];
      lineData[curIdx] <= vbData[vbHitIdx];
      vbLine[vbHitIdx] <= evictLine;
      vbData[vbHitIdx] <= lineData[curIdx];
    end
    if (strobes.doFill) begin
      lineTag[curIdx]  <= curTag;
      lineData[curIdx] <= memRespLine;
      if (lineValid[curIdx]) begin
        vbLine[vbPtr] <= evictLine;
        vbData[vbPtr] <= lineData[curIdx];
      end
    end
  end

  // response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respRdata <= '0;
    end else begin
      respValid <= strobes.doAccess;
      if (strobes.doAccess) respRdata <= lineData[curIdx][wordLsb +: WORD_W];
    end
  end

  assign memReqAddr  = strobes.selWb ? {vbLine[vbPtr], {OFF_W{1'b0}}}
                                     : (curAddr & ~ADDR_W'(LINE_BYTES - 1));
  assign memReqWline = vbData[vbPtr];

  // R5
  vb_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vbMatch));

  // R5
  swap_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doSwap |=> mainHit);

  // R4
  fill_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doFill |=> mainHit);

  // R7
  fifo_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doFill |=> $stable(vbPtr));

endmodule

// File: rtl/vcache_ctrl.sv
module vcache_ctrl
  import vcache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         mainHit,
  input  logic         vbHit,
  input  logic         needWb,
  input  logic         memReqReady,
  input  logic         memRespValid,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         memReqWrite,
  output ctrlStrobes_t strobes
);

  cacheState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:     if (reqValid) stateNext = S_LOOKUP;
      S_LOOKUP:   stateNext = mainHit ? S_IDLE : S_VSEARCH;
      S_VSEARCH:  stateNext = vbHit ? S_LOOKUP : (needWb ? S_WBREQ : S_FILLREQ);
      S_WBREQ:    if (memReqReady) stateNext = S_FILLREQ;
      S_FILLREQ:  if (memReqReady) stateNext = S_FILLWAIT;
      S_FILLWAIT: if (memRespValid) stateNext = S_LOOKUP;
      default:    stateNext = S_IDLE;
    endcase
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_WBREQ) || (state == S_FILLREQ);
  assign memReqWrite = (state == S_WBREQ);

  always_comb begin
    strobes          = '0;
    strobes.latchReq = (state == S_IDLE) && reqValid;
    strobes.doAccess = (state == S_LOOKUP) && mainHit;
    strobes.doSwap   = (state == S_VSEARCH) && vbHit;
    strobes.doFill   = (state == S_FILLWAIT) && memRespValid;
    strobes.selWb    = (state == S_WBREQ);
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqWrite));

  // R5
  no_vb_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqWrite |-> !vbHit && !mainHit);

  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite && memReqReady |=> memReqValid && !memReqWrite);

endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache
  import vcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 16,
  parameter int VB_DEPTH   = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic                         reqWrite,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [WORD_W-1:0]            reqWdata,
  output logic                         respValid,
  output logic [WORD_W-1:0]            respRdata,
  output logic                         memReqValid,
  input  logic                         memReqReady,
  output logic                         memReqWrite,
  output logic [ADDR_W-1:0]            memReqAddr,
  output logic [WORD_W*LINE_WORDS-1:0] memReqWline,
  input  logic                         memRespValid,
  input  logic [WORD_W*LINE_WORDS-1:0] memRespLine
);

  ctrlStrobes_t strobes;
  logic mainHit, vbHit, needWb;

  vcache_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .mainHit      (mainHit),
    .vbHit        (vbHit),
    .needWb       (needWb),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .memReqWrite  (memReqWrite),
    .strobes      (strobes)
  );

  vcache_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS),
    .SETS       (SETS),
    .VB_DEPTH   (VB_DEPTH)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .memRespLine (memRespLine),
    .mainHit     (mainHit),
    .vbHit       (vbHit),
    .needWb      (needWb),
    .respValid   (respValid),
    .respRdata   (respRdata),
    .memReqAddr  (memReqAddr),
    .memReqWline (memReqWline)
  );

  // R10
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> reqReady);

endmodule

// File: tb/test_dm_victim_cache.sv
module test_dm_victim_cache;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid;
  logic         reqReady;
  logic         reqWrite;
  logic [31:0]  reqAddr;
  logic [31:0]  reqWdata;
  logic         respValid;
  logic [31:0]  respRdata;
  logic         memReqValid;
  logic         memReqReady;
  logic         memReqWrite;
  logic [31:0]  memReqAddr;
  logic [127:0] memReqWline;
  logic         memRespValid;
  logic [127:0] memRespLine;

  dm_victim_cache i_dm_victim_cache (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [31:0] memWords [512];
  logic [31:0] shadow   [512];
  int compared = 0;
  int mismatched = 0;
  int memReads = 0;
  int memWrites = 0;
  logic [31:0] lastRdAddr = '0;
  logic [31:0] lastWbAddr = '0;
  bit readyRandom = 1'b0;
  bit finished = 1'b0;

  function automatic logic [31:0] mkAddr(int tag, int idx, int wd);
    return {21'b0, tag[2:0], idx[3:0], wd[1:0], 2'b00};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // next-level memory model
  initial begin
    int respDelay;
    logic [31:0] rdAddr;
    respDelay = -1;
    rdAddr = '0;
    memReqReady = 1'b0;
    memRespValid = 1'b0;
    memRespLine = '0;
    forever begin
      @(negedge clk);
      memRespValid = 1'b0;
      if (respDelay > 0) respDelay--;
      else if (respDelay == 0) begin
        for (int w = 0; w < 4; w++) memRespLine[32*w +: 32] = memWords[{rdAddr[10:4], 2'(w)}];
        memRespValid = 1'b1;
        respDelay = -1;
      end
      memReqReady = readyRandom ? (($urandom % 4) != 0) : 1'b1;
      if (rstN && memReqValid && memReqReady) begin
        if (memReqWrite) begin
          for (int w = 0; w < 4; w++) memWords[{memReqAddr[10:4], 2'(w)}] = memReqWline[32*w +: 32];
          memWrites++;
          lastWbAddr = memReqAddr;
        end else begin
          rdAddr = memReqAddr;
          lastRdAddr = memReqAddr;
          respDelay = $urandom % 3;
          memReads++;
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wdata,
                        output logic [31:0] rdata, output int lat);
    int waitCnt;
    waitCnt = 0;
    @(negedge clk);
    while (!reqReady && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = addr;
    reqWdata = wdata;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!respValid && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    rdata = respRdata;
    if (wr) shadow[addr[10:2]] = wdata;
  endtask

  task automatic rd(input logic [31:0] addr, output logic [31:0] data, output int lat);
    access(1'b0, addr, '0, data, lat);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] data;
    int lat, r0, w0;
    void'($urandom(32'd20250611));
    for (int i = 0; i < 512; i++) begin
      memWords[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      shadow[i]   = memWords[i];
    end
    rstN = 1'b0;
    reqValid = 1'b0;
    reqWrite = 1'b0;
    reqAddr = '0;
    reqWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reqReady", 32'(reqReady), 32'd1);
    check("R1 respValid", 32'(respValid), 32'd0);
    check("R1 memReqValid", 32'(memReqValid), 32'd0);

    // R4 first access misses and fetches the aligned line
    r0 = memReads;
    rd(mkAddr(1, 3, 2), data, lat);
    check("R1 first miss read", 32'(memReads - r0), 32'd1);
    check("R4 line addr", lastRdAddr, mkAddr(1, 3, 0));
    check("R4 data", data, shadow[mkAddr(1, 3, 2) >> 2]);

    // R2 array hit
    r0 = memReads;
    rd(mkAddr(1, 3, 0), data, lat);
    check("R2 hit data", data, shadow[mkAddr(1, 3, 0) >> 2]);
    check("R2 no traffic", 32'(memReads - r0), 32'd0);
    check("R10 hit latency", 32'(lat), 32'd1);

    // R3 write hit
    r0 = memReads;
    w0 = memWrites;
    access(1'b1, mkAddr(1, 3, 1), 32'hCAFE0001, data, lat);
    check("R3 write latency", 32'(lat), 32'd1);
    rd(mkAddr(1, 3, 1), data, lat);
    check("R3 readback", data, 32'hCAFE0001);
    rd(mkAddr(1, 3, 3), data, lat);
    check("R3 neighbour word", data, shadow[mkAddr(1, 3, 3) >> 2]);
    check("R3 no traffic", 32'(memReads - r0 + memWrites - w0), 32'd0);

    // R7 five evictions into one set
    for (int t = 0; t < 6; t++) rd(mkAddr(t, 5, 0), data, lat);
    r0 = memReads;
    rd(mkAddr(1, 5, 2), data, lat);
    check("R5 victim hit data", data, shadow[mkAddr(1, 5, 2) >> 2]);
    check("R5 victim hit no read", 32'(memReads - r0), 32'd0);
    check("R10 victim latency", 32'(lat), 32'd3);
    rd(mkAddr(0, 5, 1), data, lat);
    check("R7 oldest discarded", 32'(memReads - r0), 32'd1);
    check("R7 data", data, shadow[mkAddr(0, 5, 1) >> 2]);

    // R8 / R9 write-back of a dirty slot
    w0 = memWrites;
    access(1'b1, mkAddr(1, 9, 2), 32'hD1D1D1D1, data, lat);
    for (int t = 2; t < 6; t++) rd(mkAddr(t, 9, 0), data, lat);
    check("R9 clean drops", 32'(memWrites - w0), 32'd0);
    rd(mkAddr(6, 9, 0), data, lat);
    check("R8 one writeback", 32'(memWrites - w0), 32'd1);
    check("R8 wb addr", lastWbAddr, mkAddr(1, 9, 0));
    check("R8 wb data", memWords[mkAddr(1, 9, 2) >> 2], 32'hD1D1D1D1);
    rd(mkAddr(1, 9, 2), data, lat);
    check("R8 refetched dirty data", data, 32'hD1D1D1D1);

    // R6 ping-pong
    rd(mkAddr(1, 12, 0), data, lat);
    rd(mkAddr(2, 12, 0), data, lat);
    r0 = memReads;
    for (int k = 0; k < 8; k++) begin
      rd(mkAddr(1 + (k % 2), 12, k % 4), data, lat);
      check("R6 ping-pong data", data, shadow[mkAddr(1 + (k % 2), 12, k % 4) >> 2]);
    end
    check("R6 no refills", 32'(memReads - r0), 32'd0);

    // R2 R5 R8 random traffic with a stalling memory
    readyRandom = 1'b1;
    for (int n = 0; n < 400; n++) begin
      int tg, ix, wd;
      bit wr;
      logic [31:0] a, v, exp;
      tg  = $urandom % 8;
      ix  = $urandom % 4;
      wd  = $urandom % 4;
      wr  = ($urandom % 10) < 4;
      v   = $urandom;
      a   = mkAddr(tg, ix, wd);
      exp = shadow[a[10:2]];
      access(wr, a, v, data, lat);
      if (!wr) check("R5 random read", data, exp);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule